// File: doc/BRIEF.md
# Static memory bus timing generator

This block drives the strobes of an asynchronous static-memory bus with six chip selects. A requester hands over one access at a time: chip select index, direction, address, write data and byte enables. The block then runs a cycle counter from zero and derives the chip select, read strobe, write strobe and byte-lane strobes from it. It returns a one-cycle done pulse, and read data for reads.

Each chip select owns four 32-bit timing words in a small register bank. The word address is `{cs, reg}`, so chip select n starts at byte offset n×0x10. The words give a setup count and a pulse count for the chip select and for the strobe, one set per direction. They also give a cycle length per direction, the data width, the wait-input mode, the edge on which reads are sampled or write data is released, the byte-lane style, and a data-float count.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole access. After a read, it also stays low for the data-float window to any chip select that the window blocks, and it may depend on `req_cs`. A requester must hold its request stable while `req_ready` is low. The done pulse and read data are plain outputs with no back-pressure.

Top module: `smc_timing_top`

## Requirements
- R1: After reset, every chip select, the read strobe, the write strobe and all lane strobes are high (inactive), `rsp_done` is 0 and `req_ready` is 1.
- R2: Register word `{cs,reg}` selects chip select `cs`. The reg values are 0 = setup, 1 = pulse, 2 = cycle and 3 = mode. In setup and pulse, bits [5:0] hold the read chip-select count, [13:8] the read strobe count, [21:16] the write chip-select count and [29:24] the write strobe count. In cycle, [8:0] is the read length and [24:16] the write length. In mode, [1:0] is the width (0 = 8, 1 = 16, other = 32 bits), [5:4] the wait mode, [8] the read edge, [9] the write edge, [12] the byte-lane style, [19:16] the float count and [20] the float-mode bit.
- R3: Cycles of an access are numbered from 0 starting with the cycle after acceptance. A signal with setup S and pulse P is active in cycles S to S+P-1. A pulse of 0 keeps it inactive for the whole access. Only the addressed chip select ever goes low.
- R4: An access lasts L = max(programmed length, chip-select S+P+1, strobe S+P+1) cycles. `rsp_done` is high for exactly the one cycle that follows.
- R5: In wait mode 2 (frozen), the cycle counter holds during every cycle in which `mem_wait` is high.
- R6: In wait mode 3 (ready), the counter holds in the strobe's last pulse cycle while `mem_wait` is high, so the strobe stays active. In modes 0 and 1, `mem_wait` has no effect.
- R7: Read data is captured at the end of the read strobe's last pulse cycle when the read-edge bit is 1, and at the end of the chip select's last pulse cycle when it is 0. Only the lanes within the width are kept; the others read as zero.
- R8: On writes, `mem_doe` is high from cycle 0 up to the end of the write strobe pulse when the write-edge bit is 1, or up to the end of the chip-select pulse when it is 0.
- R9: Lane l is used only if it is within the width. With the style bit at 1, the lanes follow the strobe window (gated by the byte enables on writes) and `mem_we_n` stays high. With the style bit at 0, the lanes follow the chip-select window and `mem_we_n` pulses.
- R10: After a read with float count F ends, a request to another chip select is held off for F cycles, counting from the done cycle. If the float-mode bit was 1, a request to the same chip select is held off as well.
- R11: A register write made during an access does not change that access; the next access uses it.
- R12: `req_ready` is low in every cycle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address {cs, reg} |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted when high with valid |
| req_cs | input | 3 | Chip select index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Access address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | 32 | Captured read data |
| mem_cs_n | output | 6 | Chip selects, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lane_n | output | 4 | Byte-lane strobes, active low |
| mem_addr | output | 24 | Address held for the access |
| mem_dout | output | 32 | Write data to the bus |
| mem_doe | output | 1 | Write data drive enable |
| mem_din | input | 32 | Read data from the bus |
| mem_wait | input | 1 | External wait, active high |

## Verification
The bench builds the block with its defaults: six chip selects, a 32-bit data bus and 6-bit setup and pulse counts. This allows per-lane gating at all three widths and chip-select decoding across several indices. The bench changes `mem_din` in every access cycle, so the captured word shows which cycle was sampled. It drives wait patterns that cover the hold cases, and it counts the cycles that `req_ready` stays low to measure the float window.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int CNT_W = 6;
  localparam int CYC_W = 9;
  localparam int TDF_W = 4;

  typedef enum logic [1:0] {
    WAIT_OFF    = 2'd0,
    WAIT_RSVD   = 2'd1,
    WAIT_FROZEN = 2'd2,
    WAIT_READY  = 2'd3
  } wait_mode_e;

  typedef struct packed {
    logic [CNT_W-1:0] cs_setup;
    logic [CNT_W-1:0] cs_pulse;
    logic [CNT_W-1:0] st_setup;
    logic [CNT_W-1:0] st_pulse;
    logic [CYC_W-1:0] length;
    logic [1:0]       width;
    wait_mode_e       wmode;
    logic             edge_sel;
    logic             bat;
    logic [TDF_W-1:0] tdf;
    logic             tdf_mode;
  } acc_cfg_t;

  // Picks the fields for one direction and stretches the length to the minimum.
  function automatic acc_cfg_t resolve_cfg(input logic [31:0] s, input logic [31:0] p,
                                           input logic [31:0] c, input logic [31:0] m,
                                           input logic wr);
    acc_cfg_t r;
    logic [CYC_W-1:0] lim, need_cs, need_st;
    r.cs_setup = wr ? s[16 +: CNT_W] : s[0 +: CNT_W];
    r.st_setup = wr ? s[24 +: CNT_W] : s[8 +: CNT_W];
    r.cs_pulse = wr ? p[16 +: CNT_W] : p[0 +: CNT_W];
    r.st_pulse = wr ? p[24 +: CNT_W] : p[8 +: CNT_W];
    lim        = wr ? c[16 +: CYC_W] : c[0 +: CYC_W];
    need_cs    = CYC_W'(r.cs_setup) + CYC_W'(r.cs_pulse) + CYC_W'(1);
    need_st    = CYC_W'(r.st_setup) + CYC_W'(r.st_pulse) + CYC_W'(1);
    if (need_cs > lim) lim = need_cs;
    if (need_st > lim) lim = need_st;
    r.length   = lim;
    r.width    = m[1:0];
    r.wmode    = wait_mode_e'(m[5:4]);
    r.edge_sel = wr ? m[9] : m[8];
    r.bat      = m[12];
    r.tdf      = m[16 +: TDF_W];
    r.tdf_mode = m[20];
    return r;
  endfunction
endpackage

// File: rtl/smc_cfg_bank.sv
module smc_cfg_bank #(
  parameter int N_CS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(N_CS)+1:0]    wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [$clog2(N_CS)-1:0]    rd_sel,
  output logic [31:0]                setup_o,
  output logic [31:0]                pulse_o,
  output logic [31:0]                cycle_o,
  output logic [31:0]                mode_o
);
  localparam int IDX_W = $clog2(N_CS);
  localparam int WORDS = N_CS * 4;

  logic [31:0] regs [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) regs[i] <= '0;
    end else if (wr_en && (int'(wr_addr) < WORDS)) begin
      regs[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    setup_o = '0;
    pulse_o = '0;
    cycle_o = '0;
    mode_o  = '0;
    if (int'(rd_sel) < N_CS) begin
      setup_o = regs[{rd_sel, 2'd0}];
      pulse_o = regs[{rd_sel, 2'd1}];
      cycle_o = regs[{rd_sel, 2'd2}];
      mode_o  = regs[{rd_sel, 2'd3}];
    end
  end

  logic [IDX_W-1:0] unused_w;
  assign unused_w = rd_sel;
endmodule

// File: rtl/smc_window.sv
module smc_window #(
  parameter int CNT_W = 6,
  parameter int CYC_W = 9
) (
  input  logic [CYC_W-1:0] cnt,
  input  logic [CNT_W-1:0] setup,
  input  logic [CNT_W-1:0] pulse,
  output logic             active,
  output logic             last,
  output logic             pending
);
  logic [CYC_W-1:0] stop;
  assign stop    = CYC_W'(setup) + CYC_W'(pulse);
  assign active  = (pulse != '0) && (cnt >= CYC_W'(setup)) && (cnt < stop);
  assign last    = (pulse != '0) && (cnt == stop - 1'b1);
  assign pending = cnt < stop;
endmodule

// File: rtl/smc_float_guard.sv
module smc_float_guard #(
  parameter int IDX_W = 3,
  parameter int TDF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             rd_end,
  input  logic [IDX_W-1:0] end_cs,
  input  logic [TDF_W-1:0] end_tdf,
  input  logic             end_mode,
  input  logic [IDX_W-1:0] req_cs,
  output logic             allow
);
  logic [TDF_W-1:0] flt;
  logic [IDX_W-1:0] last_cs;
  logic             last_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt       <= '0;
      last_cs   <= '0;
      last_mode <= 1'b0;
    end else if (rd_end) begin
      flt       <= end_tdf;
      last_cs   <= end_cs;
      last_mode <= end_mode;
    end else if (flt != '0) begin
      flt <= flt - 1'b1;
    end
  end

  assign allow = (flt == '0) || ((req_cs == last_cs) && !last_mode);

  a_r10_float_block: assert property (@(posedge clk) disable iff (!rst_n)
    take && (flt != '0) |-> (req_cs == last_cs) && !last_mode);
endmodule

// File: rtl/smc_timing_top.sv
module smc_timing_top
  import smc_pkg::*;
#(
  parameter int N_CS   = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(N_CS)+1:0]   cfg_addr,
  input  logic [31:0]               cfg_wdata,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [$clog2(N_CS)-1:0]   req_cs,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic [DATA_W/8-1:0]       req_be,
  output logic                      rsp_done,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic [N_CS-1:0]           mem_cs_n,
  output logic                      mem_rd_n,
  output logic                      mem_we_n,
  output logic [DATA_W/8-1:0]       mem_lane_n,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_dout,
  output logic                      mem_doe,
  input  logic [DATA_W-1:0]         mem_din,
  input  logic                      mem_wait
);
  localparam int IDX_W = $clog2(N_CS);
  localparam int LANES = DATA_W / 8;

  logic [31:0] w_setup, w_pulse, w_cycle, w_mode;
  logic busy, is_wr, done_q, allow, take, stall, at_end, rd_end, sample;
  logic [CYC_W-1:0]  cnt;
  acc_cfg_t          act;
  logic [IDX_W-1:0]  cur_cs;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, din_keep;
  logic [LANES-1:0]  be_q, lane_en;
  logic [1:0]        w_act, w_last, w_pend;
  logic [CNT_W-1:0]  w_set [2];
  logic [CNT_W-1:0]  w_pul [2];

  smc_cfg_bank #(.N_CS(N_CS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .rd_sel(req_cs), .setup_o(w_setup), .pulse_o(w_pulse), .cycle_o(w_cycle), .mode_o(w_mode));

  // Window 0 is the chip select, window 1 the strobe of the current direction.
  assign w_set[0] = act.cs_setup;
  assign w_pul[0] = act.cs_pulse;
  assign w_set[1] = act.st_setup;
  assign w_pul[1] = act.st_pulse;

  for (genvar g = 0; g < 2; g++) begin : g_win
    smc_window #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_win (
      .cnt(cnt), .setup(w_set[g]), .pulse(w_pul[g]),
      .active(w_act[g]), .last(w_last[g]), .pending(w_pend[g]));
  end

  smc_float_guard #(.IDX_W(IDX_W), .TDF_W(TDF_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .take(take), .rd_end(rd_end), .end_cs(cur_cs),
    .end_tdf(act.tdf), .end_mode(act.tdf_mode), .req_cs(req_cs), .allow(allow));

  assign req_ready = !busy && allow;
  assign take      = req_valid && req_ready;
  assign stall     = busy && mem_wait &&
                     ((act.wmode == WAIT_FROZEN) || ((act.wmode == WAIT_READY) && w_last[1]));
  assign at_end    = busy && !stall && (cnt == act.length - 1'b1);
  assign rd_end    = at_end && !is_wr;
  assign sample    = busy && !is_wr && !stall && (act.edge_sel ? w_last[1] : w_last[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done_q  <= 1'b0;
      cnt     <= '0;
      is_wr   <= 1'b0;
      cur_cs  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      act     <= '0;
    end else begin
      done_q <= at_end;
      if (take) begin
        busy    <= 1'b1;
        cnt     <= '0;
        is_wr   <= req_write;
        cur_cs  <= req_cs;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
        act     <= resolve_cfg(w_setup, w_pulse, w_cycle, w_mode, req_write);
      end else if (busy && !stall) begin
        if (at_end) busy <= 1'b0;
        else        cnt  <= cnt + 1'b1;
      end
      if (sample) rdata_q <= din_keep;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l] = (act.width == 2'd0) ? (l == 0) :
                        (act.width == 2'd1) ? (l < 2) : 1'b1;
    assign din_keep[8*l +: 8] = lane_en[l] ? mem_din[8*l +: 8] : 8'h00;
    assign mem_lane_n[l] = !(busy && lane_en[l] && (is_wr ? be_q[l] : 1'b1) &&
                             (act.bat ? w_act[1] : w_act[0]));
  end

  for (genvar c = 0; c < N_CS; c++) begin : g_cs
    assign mem_cs_n[c] = !(busy && (cur_cs == IDX_W'(c)) && w_act[0]);
  end

  assign mem_rd_n  = !(busy && !is_wr && w_act[1]);
  assign mem_we_n  = !(busy && is_wr && w_act[1] && !act.bat);
  assign mem_doe   = busy && is_wr && (act.edge_sel ? w_pend[1] : w_pend[0]);
  assign mem_addr  = addr_q;
  assign mem_dout  = wdata_q;
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&mem_cs_n) && mem_rd_n && mem_we_n && (&mem_lane_n));
  a_r3_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (act.wmode == WAIT_FROZEN) && mem_wait |=> (cnt == $past(cnt)) && busy);
  a_r6_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !is_wr && (act.wmode == WAIT_READY) && mem_wait && !mem_rd_n && w_last[1]
    |=> !mem_rd_n);
  a_r12_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(busy) && !req_ready || !busy);
endmodule

// File: tb/smc_timing_top_bench.sv
module smc_timing_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [4:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        req_valid = 0, req_write = 0;
  logic        req_ready, rsp_done, mem_rd_n, mem_we_n, mem_doe;
  logic [2:0]  req_cs = 0;
  logic [23:0] req_addr = 0, mem_addr;
  logic [31:0] req_wdata = 0, rsp_rdata, mem_dout, mem_din = 0;
  logic [3:0]  req_be = 0, mem_lane_n;
  logic [5:0]  mem_cs_n;
  logic        mem_wait = 0;

  int n_chk = 0, n_fail = 0;
  int len, w_from = 0, w_to = 0, mid_k = -1;
  logic [4:0]  mid_addr;
  logic [31:0] mid_data;
  logic [31:0] cs_m, st_m, oe_m, rdy_m;
  logic [3:0]  lane_at [64];
  logic [5:0]  csv_at [64];

  smc_timing_top u_smc_timing_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n),
    .mem_lane_n(mem_lane_n), .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_din(mem_din), .mem_wait(mem_wait));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, a, e);
    end
  endtask

  task automatic cfg_write(input int cs, input int rg, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = {cs[2:0], rg[1:0]}; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic program_cs(input int cs, input logic [31:0] s, p, c, m);
    cfg_write(cs, 0, s); cfg_write(cs, 1, p); cfg_write(cs, 2, c); cfg_write(cs, 3, m);
  endtask

  // Runs one access and records per-cycle traces, cycle 0 after acceptance.
  task automatic run(input int cs, input bit wr, input logic [23:0] a, input logic [31:0] d,
                     input logic [3:0] be);
    @(negedge clk);
    req_cs = cs[2:0]; req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 req_valid = 0;
    cs_m = 0; st_m = 0; oe_m = 0; rdy_m = 0; len = 99;
    for (int k = 0; k < 64; k++) begin
      mem_din  = 32'hA1B2_C300 | k;
      mem_wait = (k >= w_from) && (k < w_to);
      if (k == mid_k) begin cfg_we = 1; cfg_addr = mid_addr; cfg_wdata = mid_data; end
      else cfg_we = 0;
      @(negedge clk);
      if (rsp_done) begin len = k; break; end
      if (k < 32) begin
        cs_m[k]  = ~&mem_cs_n;
        st_m[k]  = wr ? ~mem_we_n : ~mem_rd_n;
        oe_m[k]  = mem_doe;
        rdy_m[k] = req_ready;
      end
      lane_at[k] = ~mem_lane_n;
      csv_at[k]  = ~mem_cs_n;
      @(posedge clk); #1;
    end
    cfg_we = 0; mem_wait = 0; mid_k = -1; w_from = 0; w_to = 0;
  endtask

  // At the done cycle, presents a read to cs and counts cycles until accepted.
  task automatic float_probe(input int cs, input int exp, input string what);
    int n = 0;
    req_cs = cs[2:0]; req_write = 0; req_valid = 1;
    #1;
    while (!req_ready && n < 40) begin n++; @(negedge clk); #1; end
    chk("R10", what, n, exp);
    @(posedge clk); #1 req_valid = 0;
    for (int i = 0; i < 40 && !rsp_done; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "cs_n", mem_cs_n, 6'h3F);
    chk("R1", "rd/we", {mem_rd_n, mem_we_n}, 2'b11);
    chk("R1", "lanes", mem_lane_n, 4'hF);
    chk("R1", "done/ready", {rsp_done, req_ready}, 2'b01);
  endtask

  task automatic t_basic_read;
    program_cs(0, 32'h0000_0201, 32'h0000_0204, 32'h3, 32'h0000_0102);
    run(0, 0, 24'h00_1000, 0, 4'h0);
    chk("R4", "extended length", len, 6);
    chk("R3", "cs window", cs_m, 32'h1E);
    chk("R3", "rd window", st_m, 32'hC);
    chk("R3", "only cs0", csv_at[1], 6'b000001);
    chk("R7", "rdata at rd edge", rsp_rdata, 32'hA1B2_C303);
    chk("R12", "ready low while busy", rdy_m, 32'h0);
    chk("R4", "done single", rsp_done, 1'b1);
    @(negedge clk);
    chk("R4", "done falls", rsp_done, 1'b0);
  endtask

  task automatic t_cs_edge_half;
    cfg_write(0, 3, 32'h0000_0001);
    run(0, 0, 24'h00_2000, 0, 4'h0);
    chk("R7", "rdata at cs edge, 16-bit", rsp_rdata, 32'h0000_C304);
    chk("R9", "read lanes cycle2", lane_at[2], 4'b0011);
    chk("R9", "read lanes cycle0", lane_at[0], 4'b0000);
  endtask

  task automatic t_long_cycle;
    program_cs(1, 32'h0, 32'h0000_0102, 32'd10, 32'h2);
    run(1, 0, 24'h00_0040, 0, 4'h0);
    chk("R4", "programmed length", len, 10);
    chk("R2", "cs1 selected", csv_at[0], 6'b000010);
    chk("R3", "cs1 window", cs_m, 32'h3);
    chk("R3", "rd window", st_m, 32'h1);
  endtask

  task automatic t_zero_counts;
    program_cs(0, 32'h0, 32'h0000_0003, 32'h0, 32'h2);
    run(0, 0, 24'h0, 0, 4'h0);
    chk("R3", "zero setup cs", cs_m, 32'h7);
    chk("R3", "zero pulse rd", st_m, 32'h0);
    chk("R4", "length", len, 4);
  endtask

  task automatic t_write_select;
    program_cs(2, 32'h0100_0000, 32'h0305_0000, 32'h0, 32'h0000_0202);
    run(2, 1, 24'hAB_CDE0, 32'h1234_5678, 4'b0101);
    chk("R4", "write length", len, 6);
    chk("R3", "write cs", cs_m, 32'h1F);
    chk("R3", "we window", st_m, 32'hE);
    chk("R8", "doe to we end", oe_m, 32'hF);
    chk("R9", "select lanes", lane_at[2], 4'b0101);
    chk("R9", "lanes after cs", lane_at[5], 4'b0000);
    chk("R2", "cs2 selected", csv_at[1], 6'b000100);
    chk("R8", "dout", mem_dout, 32'h1234_5678);
    chk("R8", "addr", mem_addr, 24'hAB_CDE0);
  endtask

  task automatic t_write_bytes;
    cfg_write(2, 3, 32'h0000_1000);
    run(2, 1, 24'h10, 32'hFFFF_FFFF, 4'b1111);
    chk("R9", "we held high", st_m, 32'h0);
    chk("R9", "byte lane 8-bit", lane_at[2], 4'b0001);
    chk("R9", "lane before strobe", lane_at[0], 4'b0000);
    chk("R8", "doe to cs end", oe_m, 32'h1F);
  endtask

  task automatic t_frozen;
    program_cs(3, 32'h0000_0100, 32'h0000_0204, 32'h0, 32'h22);
    w_from = 1; w_to = 3;
    run(3, 0, 24'h0, 0, 4'h0);
    chk("R5", "frozen length", len, 7);
    chk("R5", "frozen rd", st_m, 32'h1E);
    chk("R5", "frozen cs", cs_m, 32'h3F);
  endtask

  task automatic t_ready;
    cfg_write(3, 3, 32'h32);
    w_from = 0; w_to = 6;
    run(3, 0, 24'h0, 0, 4'h0);
    chk("R6", "ready length", len, 9);
    chk("R6", "ready rd held", st_m, 32'h7E);
    cfg_write(3, 3, 32'h12);
    w_from = 0; w_to = 6;
    run(3, 0, 24'h0, 0, 4'h0);
    chk("R6", "reserved ignores wait", len, 5);
    chk("R6", "reserved rd", st_m, 32'h6);
  endtask

  task automatic t_float;
    program_cs(4, 32'h0, 32'h0000_0101, 32'h0, 32'h0003_0002);
    program_cs(5, 32'h0, 32'h0, 32'h0, 32'h0);
    run(4, 0, 24'h0, 0, 4'h0);
    float_probe(5, 3, "other cs held");
    run(4, 0, 24'h0, 0, 4'h0);
    float_probe(4, 0, "same cs free");
    cfg_write(4, 3, 32'h0013_0002);
    run(4, 0, 24'h0, 0, 4'h0);
    float_probe(4, 3, "same cs held with mode");
  endtask

  task automatic t_snapshot;
    program_cs(0, 32'h0000_0201, 32'h0000_0204, 32'h3, 32'h0000_0102);
    mid_k = 1; mid_addr = {3'd0, 2'd1}; mid_data = 32'h0000_0101;
    run(0, 0, 24'h0, 0, 4'h0);
    chk("R11", "old length", len, 6);
    chk("R11", "old rd", st_m, 32'hC);
    run(0, 0, 24'h0, 0, 4'h0);
    chk("R11", "new cs", cs_m, 32'h2);
    chk("R11", "new rd", st_m, 32'h4);
    chk("R11", "new length", len, 4);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic_read();
    t_cs_edge_half();
    t_long_cycle();
    t_zero_counts();
    t_write_select();
    t_write_bytes();
    t_frozen();
    t_ready();
    t_float();
    t_snapshot();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule